// File: doc/BRIEF.md
# Binary32 to Unsigned Integer Truncating Converter

This block turns an IEEE-754 single-precision operand into a 32-bit unsigned integer. The conversion always discards the fractional part, so the magnitude moves toward zero no matter which rounding mode the surrounding unit has configured. Each accepted operand yields one registered result one clock later, together with a two-bit exception vector that a flag register can accumulate and a single summary bit that is high whenever any exception was raised.

Operands that have no unsigned representation are handled explicitly. A NaN, and any value below zero, produce zero with the invalid flag. A positive value too large for 32 bits, including positive infinity, saturates to all ones with the invalid flag. Whenever invalid is raised, inexact is withheld, so a caller sees at most one of the two flags for a given operand.

The datapath is a single barrel shift of the 24-bit significand, followed by a classification mux, with one register stage at the output.

Top module: `f32_to_u32_trunc`

## Requirements
- R1: A result, its flags and out_valid appear one clock after the edge that samples in_valid high; out_valid is low one clock after an edge that samples in_valid low.
- R2: While rst_n is low, out_valid, out_value, out_exc and out_any are all zero.
- R3: A NaN operand (exponent field 255, fraction field non-zero, either sign) gives out_value 0 and out_exc 2'b10 (bit 1 invalid, bit 0 inexact).
- R4: Any operand strictly below zero, including negative denormals, negative fractions and negative infinity, gives out_value 0 and out_exc 2'b10.
- R5: Positive zero and negative zero give out_value 0 and out_exc 2'b00.
- R6: A positive operand of 2^32 or more, including positive infinity, gives out_value 32'hFFFF_FFFF and out_exc 2'b10.
- R7: A positive finite operand below 2^32 gives out_value equal to its value with the fraction discarded.
- R8: For a positive finite operand below 2^32, out_exc bit 0 (inexact) is set exactly when non-zero fraction bits were discarded; positive denormals and all values in (0,1) give 0 with inexact.
- R9: out_exc never reads 2'b11: invalid clears inexact.
- R10: out_any is high exactly when out_exc is non-zero, so an operand with no exception reports a zero summary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operand strobe |
| in_bits | input | 32 | Binary32 operand |
| out_valid | output | 1 | Result strobe |
| out_value | output | 32 | Unsigned integer result |
| out_exc | output | 2 | Exception vector: bit 1 invalid, bit 0 inexact |
| out_any | output | 1 | Summary: high when any exception was raised |

## Verification
Every result, flag and summary bit is due exactly one clock after the rising edge that captures the operand. The bench changes the operand on a falling edge, lets one rising edge pass and compares all outputs on the next falling edge, so each comparison sees the register written by that operand and nothing later. Idle cycles are checked the same way for a low out_valid. The sweep covers every exponent with both signs and several significand patterns, with expected values computed by integer arithmetic in the bench.

// File: rtl/f32_to_u32_trunc.sv
module f32_to_u32_trunc (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [31:0] in_bits,
  output logic        out_valid,
  output logic [31:0] out_value,
  output logic [1:0]  out_exc,
  output logic        out_any
);
  localparam int FW = 23;
  localparam int EW = 8;
  localparam int OW = 32;
  localparam int WW = OW + FW;
  localparam logic [EW-1:0] BIAS = 8'd127;
  localparam logic [EW-1:0] EMAX = BIAS + 8'(OW);

  logic          sgn;
  logic [EW-1:0] expo;
  logic [FW-1:0] frac;
  logic [EW-1:0] shamt;
  logic [WW-1:0] wide;
  logic          is_zero, is_nan, too_big, too_small, lost;

  assign sgn       = in_bits[31];
  assign expo      = in_bits[30:23];
  assign frac      = in_bits[22:0];
  assign is_zero   = (expo == '0) && (frac == '0);
  assign is_nan    = (expo == '1) && (frac != '0);
  assign too_big   = expo >= EMAX;
  assign too_small = expo < BIAS;
  assign shamt     = expo - BIAS;
  assign wide      = {{(WW-FW-1){1'b0}}, 1'b1, frac} << shamt;
  assign lost      = |wide[FW-1:0];

  logic [OW-1:0] res_d;
  logic          inv_d, inx_d, any_d;

  always_comb begin
    res_d = '0;
    inv_d = 1'b0;
    inx_d = 1'b0;
    if (is_nan) begin
      inv_d = 1'b1;
    end else if (is_zero) begin
      inv_d = 1'b0;
    end else if (sgn) begin
      inv_d = 1'b1;
    end else if (too_big) begin
      res_d = '1;
      inv_d = 1'b1;
    end else if (too_small) begin
      inx_d = 1'b1;
    end else begin
      res_d = wide[WW-1:FW];
      inx_d = lost;
    end
  end

  assign any_d = ~is_zero & (sgn | too_big | too_small | lost);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_value <= '0;
      out_exc   <= '0;
      out_any   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_value <= res_d;
        out_exc   <= {inv_d, inx_d};
        out_any   <= any_d;
      end
    end
  end

  assert_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  assert_nan_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && is_nan) |=> (out_value == '0 && out_exc == 2'b10));
  assert_negative_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && sgn && !is_zero) |=> (out_value == '0 && out_exc == 2'b10));
  assert_saturate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !sgn && expo == '1 && frac == '0) |=> (out_value == '1 && out_exc == 2'b10));
  assert_no_both_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_exc != 2'b11);
  assert_summary_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_any == (out_exc != 2'b00)));
endmodule

// File: tb/f32_to_u32_trunc_tb.sv
`timescale 1ns/1ps
module f32_to_u32_trunc_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] in_bits = '0;
  logic        out_valid;
  logic [31:0] out_value;
  logic [1:0]  out_exc;
  logic        out_any;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  f32_to_u32_trunc u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_bits(in_bits),
    .out_valid(out_valid), .out_value(out_value), .out_exc(out_exc), .out_any(out_any)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp_v, input logic [31:0] op);
    checks++;
    if (act !== exp_v) begin
      errors++;
      $display("FAIL %s op=%08h actual=%0h expected=%0h", req, op, act, exp_v);
    end
  endtask

  function automatic string req_of(input logic [31:0] x);
    logic [7:0] e = x[30:23];
    if (e == 8'hFF && x[22:0] != 0) return "R3";
    if (x[30:0] == 0) return "R5";
    if (x[31]) return "R4";
    if (e >= 8'd159) return "R6";
    return "R7/R8";
  endfunction

  task automatic model(input logic [31:0] x, output logic [31:0] v, output logic [1:0] f);
    int e;
    longint m;
    e = int'(x[30:23]);
    m = longint'({1'b1, x[22:0]});
    v = 0; f = 2'b00;
    if (e == 255 && x[22:0] != 0) f = 2'b10;
    else if (x[30:0] == 0) f = 2'b00;
    else if (x[31]) f = 2'b10;
    else if (e - 127 >= 32) begin v = 32'hFFFF_FFFF; f = 2'b10; end
    else if (e < 127) f = 2'b01;
    else if (e - 150 >= 0) v = 32'(m << (e - 150));
    else begin
      v = 32'(m / (64'd1 << (150 - e)));
      f = (m % (64'd1 << (150 - e)) != 0) ? 2'b01 : 2'b00;
    end
  endtask

  task automatic apply(input logic [31:0] x);
    logic [31:0] ev;
    logic [1:0] ef;
    string r;
    model(x, ev, ef);
    r = req_of(x);
    @(negedge clk);
    in_valid = 1'b1;
    in_bits = x;
    @(negedge clk);
    check("R1 valid", 64'(out_valid), 64'd1, x);
    check({r, " value"}, 64'(out_value), 64'(ev), x);
    check({r, " R9 flags"}, 64'(out_exc), 64'(ef), x);
    check("R10 summary", 64'(out_any), 64'(ef != 2'b00), x);
  endtask

  initial begin
    logic [22:0] pats[8];
    pats[0] = 23'h000000; pats[1] = 23'h000001; pats[2] = 23'h400000;
    pats[3] = 23'h7FFFFF; pats[4] = 23'h2AAAAA; pats[5] = 23'h155555;
    pats[6] = 23'h000100; pats[7] = 23'h7FFF00;
    repeat (3) @(negedge clk);
    check("R2 valid", 64'(out_valid), 64'd0, 0);
    check("R2 value", 64'(out_value), 64'd0, 0);
    check("R2 flags", 64'(out_exc), 64'd0, 0);
    check("R2 summary", 64'(out_any), 64'd0, 0);
    rst_n = 1'b1;
    // R5 both zeros, R6 +inf, R4 -inf, R3 NaN, R7 exact values
    apply(32'h0000_0000);
    apply(32'h8000_0000);
    apply(32'h7F80_0000);
    apply(32'hFF80_0000);
    apply(32'h7FC0_0000);
    apply(32'h4F80_0000);
    apply(32'h4F7F_FFFF);
    apply(32'h3F80_0000);
    apply(32'hBF00_0000);
    apply(32'h3FC0_0000);
    for (int s = 0; s < 2; s++)
      for (int e = 0; e < 256; e++)
        for (int p = 0; p < 8; p++)
          apply({1'(s), 8'(e), pats[p]});
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    check("R1 idle", 64'(out_valid), 64'd0, 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule